// File: doc/BRIEF.md
# Serial-Loaded Bank Register File

This block holds four small configuration registers (one control register, two 5-bit bank registers and one 4-bit program bank register) that an 8-bit CPU fills one bit at a time. Every bus write to the upper half of the 16-bit address space feeds the loader. A write with data bit 7 set is a restart command. Any other such write contributes its data bit 0 to a 5-bit assembly register. The fifth contributing write commits the assembled value to the register that its own address picks.

A marker bit sits at the top of the assembly register when it is empty. It moves down one place on every contributing write, so the block knows that a write is the fifth one when the marker has reached bit 0. No separate counter is needed. The restart command empties the assembly register and also forces two fixed bits of the control register high.

Top module: `serial_bank_regs`

## Requirements
- R1: After synchronous reset the control register reads 0x0C, both bank registers and the program bank read 0, and the loader is empty.
- R2: A cycle with the write strobe low, or a write whose address is below 0x8000 (address bit 15 clear), changes no output. It also leaves the loader's partial progress intact, even when the data has bit 7 set.
- R3: A loader write with data bit 7 clear contributes data bit 0. The bit from the first of five contributing writes becomes bit 0 of the committed value, and the bit from the fifth becomes bit 4.
- R4: The fifth contributing write commits the value to the target chosen by address bits 14:13 of that write: 0 selects the control register, 1 selects bank register A, 2 selects bank register B, and 3 selects the program bank, which takes value bits 3:0. The other registers are unchanged.
- R5: A loader write with data bit 7 set discards partial progress, sets control bits 3 and 2 to 1, and keeps control bits 4, 1 and 0 and all bank registers unchanged.
- R6: After a commit, the loader is empty, so the next five contributing writes form a new value.
- R7: The addresses of the first four contributing writes have no effect on the target; only the completing write's address counts.
- R8: Data bits 6 to 1 of a loader write are ignored.
- R9: Contributing writes one to four change no output; registers update on the clock edge of the fifth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | CPU write strobe, qualifies addr and wdata for one cycle |
| addr | input | 16 | CPU write address |
| wdata | input | 8 | CPU write data |
| ctrl_o | output | 5 | Control register |
| bank_a_o | output | 5 | Bank register A |
| bank_b_o | output | 5 | Bank register B |
| prog_bank_o | output | 4 | Program bank register |

## Verification
The hardest case to reach from the ports is a partial sequence that is disturbed part-way. Examples are a restart command after three bits, or a write below 0x8000 that carries bit 7 between the second and third bits. After the disturbance, the committed value shows whether the loader kept or lost its progress. The stimulus builds such interrupted sequences on purpose: it varies the addresses of early bits, sets the ignored data bits, and places commits back to back. It then runs a long random phase in which restart commands are rare enough that full five-bit sequences often complete. A behavioural model that holds the pending bits in a queue checks every output on every clock.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    localparam int DEF_ADDR_W = 16;
    localparam int DEF_DATA_W = 8;
    localparam int DEF_REG_W  = 5;
    localparam int DEF_PROG_W = 4;
    localparam int NUM_TGT    = 4;
    localparam int SEL_W      = $clog2(NUM_TGT);

    typedef enum logic [SEL_W-1:0] {
        TGT_CTRL   = 2'd0,
        TGT_BANK_A = 2'd1,
        TGT_BANK_B = 2'd2,
        TGT_PROG   = 2'd3
    } tgt_e;
endpackage

// File: rtl/sbr_shift_unit.sv
module sbr_shift_unit #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] cur,
    input  logic             din,
    output logic [REG_W-1:0] nxt,
    output logic             last
);
    // The marker bit reaching bit 0 means this write supplies the final bit.
    assign last = cur[0];
    assign nxt  = {din, cur[REG_W-1:1]};
endmodule

// File: rtl/sbr_commit_dec.sv
module sbr_commit_dec #(
    parameter int NUM_TGT = 4,
    parameter int SEL_W   = 2
) (
    input  logic               en,
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_TGT-1:0] we
);
    for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
        assign we[g] = en && (sel == SEL_W'(g));
    end
endmodule

// File: rtl/serial_bank_regs.sv
module serial_bank_regs
    import sbr_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int REG_W  = DEF_REG_W,
    parameter int PROG_W = DEF_PROG_W,
    parameter logic [REG_W-1:0] CTRL_RST = 5'h0C,
    parameter logic [REG_W-1:0] CMD_SET  = 5'h0C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [REG_W-1:0]  ctrl_o,
    output logic [REG_W-1:0]  bank_a_o,
    output logic [REG_W-1:0]  bank_b_o,
    output logic [PROG_W-1:0] prog_bank_o
);
    localparam logic [REG_W-1:0] EMPTY = {1'b1, {(REG_W-1){1'b0}}};
    localparam int SEL_LSB = ADDR_W - 1 - SEL_W;

    typedef struct packed {
        logic [REG_W-1:0]  shift;
        logic [REG_W-1:0]  ctrl;
        logic [REG_W-1:0]  bank_a;
        logic [REG_W-1:0]  bank_b;
        logic [PROG_W-1:0] prog;
    } state_t;

    localparam state_t RST_STATE = '{
        shift:  EMPTY,
        ctrl:   CTRL_RST,
        bank_a: '0,
        bank_b: '0,
        prog:   '0
    };

    state_t st_d, st_q;

    logic              loader_hit;
    logic              is_cmd;
    logic [REG_W-1:0]  shifted;
    logic              final_bit;
    logic [SEL_W-1:0]  tgt_sel;
    logic [NUM_TGT-1:0] tgt_we;
    logic              unused_bits;

    assign loader_hit  = wr_en && addr[ADDR_W-1];
    assign is_cmd      = wdata[DATA_W-1];
    assign tgt_sel     = addr[SEL_LSB +: SEL_W];
    assign unused_bits = ^{addr[SEL_LSB-1:0], wdata[DATA_W-2:1]};

    sbr_shift_unit #(.REG_W(REG_W)) shift_i (
        .cur  (st_q.shift),
        .din  (wdata[0]),
        .nxt  (shifted),
        .last (final_bit)
    );

    sbr_commit_dec #(.NUM_TGT(NUM_TGT), .SEL_W(SEL_W)) dec_i (
        .en  (loader_hit && !is_cmd && final_bit),
        .sel (tgt_sel),
        .we  (tgt_we)
    );

    always_comb begin
        st_d = st_q;
        if (loader_hit) begin
            if (is_cmd) begin
                st_d.shift = EMPTY;
                st_d.ctrl  = st_q.ctrl | CMD_SET;
            end else if (final_bit) begin
                st_d.shift = EMPTY;
                if (tgt_we[TGT_CTRL])   st_d.ctrl   = shifted;
                if (tgt_we[TGT_BANK_A]) st_d.bank_a = shifted;
                if (tgt_we[TGT_BANK_B]) st_d.bank_b = shifted;
                if (tgt_we[TGT_PROG])   st_d.prog   = shifted[PROG_W-1:0];
            end else begin
                st_d.shift = shifted;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RST_STATE;
        else     st_q <= st_d;
    end

    assign ctrl_o      = st_q.ctrl;
    assign bank_a_o    = st_q.bank_a;
    assign bank_b_o    = st_q.bank_b;
    assign prog_bank_o = st_q.prog;
endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int REG_W  = 5,
    parameter int PROG_W = 4,
    parameter logic [REG_W-1:0] CMD_SET = 5'h0C
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [REG_W-1:0]  ctrl_o,
    input logic [REG_W-1:0]  bank_a_o,
    input logic [REG_W-1:0]  bank_b_o,
    input logic [PROG_W-1:0] prog_bank_o
);
    localparam int CNT_W = $clog2(REG_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REG_W - 1);

    logic hit, cmd_hit, data_hit, fin;
    logic [1:0] sel;
    logic [CNT_W-1:0] cnt_q;
    logic unused_chk;

    assign hit      = wr_en && addr[ADDR_W-1];
    assign cmd_hit  = hit && wdata[DATA_W-1];
    assign data_hit = hit && !wdata[DATA_W-1];
    assign fin      = data_hit && (cnt_q == LAST);
    assign sel      = addr[ADDR_W-2 -: 2];
    assign unused_chk = ^{addr[ADDR_W-4:0], wdata[DATA_W-2:1]};

    // Independent count of contributing writes since the loader was last emptied.
    always_ff @(posedge clk) begin
        if (rst || cmd_hit || fin) cnt_q <= '0;
        else if (data_hit)         cnt_q <= cnt_q + 1'b1;
    end

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(ctrl_o) && $stable(bank_a_o) && $stable(bank_b_o) && $stable(prog_bank_o));

    assert_cmd_ctrl_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_hit |=> ((ctrl_o & CMD_SET) == CMD_SET)
                 && ((ctrl_o & ~CMD_SET) == ($past(ctrl_o) & ~CMD_SET))
                 && $stable(bank_a_o) && $stable(bank_b_o) && $stable(prog_bank_o));

    assert_no_early_commit_R9: assert property (@(posedge clk) disable iff (rst)
        (data_hit && cnt_q != LAST) |=> $stable(ctrl_o) && $stable(bank_a_o)
                 && $stable(bank_b_o) && $stable(prog_bank_o));

    assert_commit_ctrl_R4: assert property (@(posedge clk) disable iff (rst)
        (fin && sel == 2'd0) |=> ctrl_o[REG_W-1] == $past(wdata[0])
                 && $stable(bank_a_o) && $stable(bank_b_o) && $stable(prog_bank_o));

    assert_commit_bank_a_R4: assert property (@(posedge clk) disable iff (rst)
        (fin && sel == 2'd1) |=> bank_a_o[REG_W-1] == $past(wdata[0])
                 && $stable(ctrl_o) && $stable(bank_b_o) && $stable(prog_bank_o));

    assert_commit_bank_b_R4: assert property (@(posedge clk) disable iff (rst)
        (fin && sel == 2'd2) |=> bank_b_o[REG_W-1] == $past(wdata[0])
                 && $stable(ctrl_o) && $stable(bank_a_o) && $stable(prog_bank_o));

    assert_commit_prog_R4: assert property (@(posedge clk) disable iff (rst)
        (fin && sel == 2'd3) |=> $stable(ctrl_o) && $stable(bank_a_o) && $stable(bank_b_o));
endmodule

bind serial_bank_regs sbr_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W), .PROG_W(PROG_W), .CMD_SET(CMD_SET)
) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl_o(ctrl_o), .bank_a_o(bank_a_o), .bank_b_o(bank_b_o), .prog_bank_o(prog_bank_o)
);

// File: tb/serial_bank_regs_tb.sv
`timescale 1ns/1ps
module serial_bank_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  wdata = 8'h00;
    logic [4:0]  ctrl_o, bank_a_o, bank_b_o;
    logic [3:0]  prog_bank_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference
    int m_ctrl = 12, m_a = 0, m_b = 0, m_p = 0;
    int pend[$];

    always #2 clk = ~clk;

    serial_bank_regs dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .ctrl_o(ctrl_o), .bank_a_o(bank_a_o), .bank_b_o(bank_b_o), .prog_bank_o(prog_bank_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 12; m_a = 0; m_b = 0; m_p = 0;
            pend.delete();
        end else if (wr_en && addr >= 16'h8000) begin
            if (wdata[7]) begin
                pend.delete();
                m_ctrl = m_ctrl | 12;
            end else begin
                pend.push_back(int'(wdata[0]));
                if (pend.size() == 5) begin
                    int v;
                    v = 0;
                    foreach (pend[i]) v = v + (pend[i] << i);
                    case ((addr - 16'h8000) / 16'h2000)
                        0: m_ctrl = v;
                        1: m_a = v;
                        2: m_b = v;
                        default: m_p = v % 16;
                    endcase
                    pend.delete();
                end
            end
        end
    end

    task automatic cmp(string name, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h at %0t", tag, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            cmp("ctrl", int'(ctrl_o), m_ctrl);
            cmp("bank_a", int'(bank_a_o), m_a);
            cmp("bank_b", int'(bank_b_o), m_b);
            cmp("prog", int'(prog_bank_o), m_p);
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input logic [15:0] a, input logic [7:0] d);
        wr_en = 1'b0; addr = a; wdata = d;
        @(negedge clk);
    endtask

    task automatic send5(input logic [15:0] a, input int v);
        for (int i = 0; i < 5; i++) wr(a, 8'((v >> i) & 1));
    endtask

    task automatic expect_now(string t, int c, int a, int b, int p);
        tag = t;
        cmp("ctrl direct", int'(ctrl_o), c);
        cmp("bank_a direct", int'(bank_a_o), a);
        cmp("bank_b direct", int'(bank_b_o), b);
        cmp("prog direct", int'(prog_bank_o), p);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_now("R1", 12, 0, 0, 0);

        tag = "R3"; send5(16'h8000, 5'b01101);
        expect_now("R3", 13, 0, 0, 0);

        tag = "R4"; send5(16'hA000, 5'h15);
        send5(16'hC000, 5'h0A);
        send5(16'hE000, 5'h1F);
        expect_now("R4", 13, 5'h15, 5'h0A, 4'hF);
        send5(16'hFFFF, 5'h06);
        expect_now("R4", 13, 5'h15, 5'h0A, 4'h6);

        tag = "R9"; wr(16'hA000, 8'h00); wr(16'hA000, 8'h01); wr(16'hA000, 8'h01);
        expect_now("R9", 13, 5'h15, 5'h0A, 4'h6);
        wr(16'hA000, 8'h00); wr(16'hA000, 8'h01);
        expect_now("R9", 13, 5'h16, 5'h0A, 4'h6);

        tag = "R2"; wr(16'hA000, 8'h01); wr(16'hA000, 8'h01);
        wr(16'h7FFF, 8'h80); wr(16'h0000, 8'h01); wr(16'h6000, 8'h00);
        idle(16'h8000, 8'h80); idle(16'hE000, 8'h01);
        expect_now("R2", 13, 5'h16, 5'h0A, 4'h6);
        wr(16'hA000, 8'h00); wr(16'hA000, 8'h00); wr(16'hA000, 8'h00);
        expect_now("R2", 13, 5'h03, 5'h0A, 4'h6);

        tag = "R5"; send5(16'h8000, 5'h00);
        wr(16'hC000, 8'h01); wr(16'hC000, 8'h01); wr(16'hC000, 8'h01);
        wr(16'h8000, 8'h80);
        expect_now("R5", 12, 5'h03, 5'h0A, 4'h6);
        send5(16'hC000, 5'h04);
        expect_now("R5", 12, 5'h03, 5'h04, 4'h6);
        send5(16'h8000, 5'h13);
        wr(16'hE000, 8'hFF);
        expect_now("R5", 5'h1F, 5'h03, 5'h04, 4'h6);

        tag = "R6"; send5(16'hA000, 5'h09); send5(16'hA000, 5'h12);
        expect_now("R6", 5'h1F, 5'h12, 5'h04, 4'h6);

        tag = "R7"; wr(16'h8000, 8'h01); wr(16'hE000, 8'h00); wr(16'hA000, 8'h01);
        wr(16'h9FFF, 8'h01); wr(16'hC123, 8'h01);
        expect_now("R7", 5'h1F, 5'h12, 5'h1D, 4'h6);

        tag = "R8"; wr(16'hE000, 8'h7E); wr(16'hE000, 8'h7F); wr(16'hE000, 8'h02);
        wr(16'hE000, 8'h41); wr(16'hE000, 8'h00);
        expect_now("R8", 5'h1F, 5'h12, 5'h1D, 4'hA);

        tag = "R4";
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            logic [7:0] d;
            a = 16'($urandom);
            d = 8'($urandom);
            if ($urandom_range(0, 15) != 0) d[7] = 1'b0;
            if ($urandom_range(0, 5) == 0) idle(a, d);
            else wr(a, d);
        end

        tag = "R1"; rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        expect_now("R1", 12, 0, 0, 0);
        finish_run();
    end
endmodule